// File: doc/BRIEF.md
# Program Counter Sequencer with One Delay Slot and Link

This block holds the fetch address of a small 32-bit pipeline and chooses its next value every cycle. Without a redirect the address steps to the following word. A branch that the decode stage resolves (a conditional compare, a relative branch or a jump through a register) changes the address only at the next clock edge. By then the word after the branch is already being fetched, so that one instruction, the delay slot, always executes.

Fetch also has its own path. An unconditional relative branch seen in fetch adds its sign-extended, word-scaled offset to the address of the following word in a dedicated adder. It then redirects on the next edge with no delay slot. Both kinds of branch can be used together. When both ask in the same cycle, the decode request wins because it belongs to the older instruction.

For branch-and-link the block produces the return address, which is the branch address plus 8 so that a return skips the delay slot. It also produces the fixed link register index and a one-cycle write strobe.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst` is high, and on the first sampling after it falls, `fetch_addr` reads 0x00400000.
- R2: While `fetch_en` is low, `fetch_addr` keeps its value across the edge, every branch request is ignored, and `link_we` stays 0.
- R3: With `fetch_en` high and no request, `fetch_addr` rises by 4 at each edge.
- R4: With `fetch_en` and `dec_take` high and `dec_reg_jump` low, `fetch_addr` becomes `dec_target` at the next edge. The address fetched during the request cycle (the delay slot) is fetched exactly once before the target.
- R5: A decode request with `dec_take` low does not redirect: the address still advances by 4, and `link_we` stays 0 even when `dec_link` is high.
- R6: With `dec_take` and `dec_reg_jump` high, the next `fetch_addr` is `dec_reg_value`, and `dec_target` is ignored.
- R7: `link_we` is high in exactly the cycles where `fetch_en`, `dec_take` and `dec_link` are all high. In those cycles `link_addr` equals `dec_pc + 8`, and `link_idx` always reads 31.
- R8: With `fetch_en` and `fe_ubr` high and `dec_take` low, the next `fetch_addr` is the current address + 4 + (sign-extended `fe_imm` shifted left by 2), for both positive and negative offsets.
- R9: When `fe_ubr` and `dec_take` are both high with `fetch_en`, the decode target (register value or `dec_target`) is taken and the fetch offset is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fetch_en | input | 1 | Allows the address to change this cycle |
| fe_ubr | input | 1 | Fetched word is an unconditional relative branch |
| fe_imm | input | 16 | Word offset of that branch, signed |
| dec_take | input | 1 | Decode has resolved a taken branch |
| dec_target | input | 32 | Target computed by decode |
| dec_link | input | 1 | Decode branch also writes the return address |
| dec_reg_jump | input | 1 | Target comes from the register value |
| dec_reg_value | input | 32 | Register operand for a register jump |
| dec_pc | input | 32 | Address of the branch sitting in decode |
| fetch_addr | output | 32 | Current fetch address |
| link_addr | output | 32 | Return address for the link write |
| link_idx | output | 5 | Register index for the link write |
| link_we | output | 1 | Link register write strobe |

## Verification
The hardest case to reach is a decode-stage register jump with link arriving in the same cycle that fetch reports its own unconditional branch. Here the priority rule, the target source and the return address must all be right at once. The bench's vector table builds up to it step by step from a known address. It first reaches the delay slot through an ordinary taken branch, then uses fetch-path branches with positive and negative offsets. Finally it applies the colliding request and a stalled cycle carrying live requests, with each expected address worked out in sequence from the reset value.

// File: rtl/pcseq_pkg.sv
`timescale 1ns/1ps
package pcseq_pkg;

   // Source chosen for the next fetch address
   typedef enum logic [1:0] {
      SEL_HOLD  = 2'd0,
      SEL_SEQ   = 2'd1,
      SEL_DEC   = 2'd2,
      SEL_FETCH = 2'd3
   } pc_sel_e;

   localparam int unsigned DEF_XLEN      = 32;
   localparam int unsigned DEF_IMM_W     = 16;
   localparam int unsigned DEF_REG_IDX_W = 5;
   localparam int unsigned DEF_LINK_REG  = 31;
   localparam int unsigned WORD_BYTES    = 4;

endpackage

// File: rtl/pcseq_fetch_target.sv
`timescale 1ns/1ps
// Fetch-stage target adder for unconditional relative branches.
module pcseq_fetch_target #(
   parameter int unsigned XLEN     = 32,
   parameter int unsigned IMM_W    = 16,
   parameter bit          ENABLE   = 1'b1
) (
   input  logic [XLEN-1:0]  cur_pc,
   input  logic             req,
   input  logic [IMM_W-1:0] imm,
   output logic             hit,
   output logic [XLEN-1:0]  target
);
   localparam int unsigned EXT_W = XLEN - IMM_W - 2;
   localparam logic [XLEN-1:0] STEP = XLEN'(pcseq_pkg::WORD_BYTES);

   generate
      if (ENABLE) begin : g_adder
         logic [XLEN-1:0] offset;
         assign offset = {{EXT_W{imm[IMM_W-1]}}, imm, 2'b00};
         assign hit    = req;
         assign target = cur_pc + STEP + offset;
      end else begin : g_none
         logic unused_inputs;
         assign unused_inputs = req ^ (^imm) ^ (^cur_pc);
         assign hit    = 1'b0;
         assign target = '0;
      end
   endgenerate
endmodule

// File: rtl/pcseq_select.sv
`timescale 1ns/1ps
// Chooses the next-address source; decode outranks fetch.
module pcseq_select #(
   parameter int unsigned XLEN = 32
) (
   input  logic                      fetch_en,
   input  logic                      dec_take,
   input  logic                      dec_reg_jump,
   input  logic [XLEN-1:0]           dec_target,
   input  logic [XLEN-1:0]           dec_reg_value,
   input  logic                      fe_hit,
   output pcseq_pkg::pc_sel_e        sel,
   output logic [XLEN-1:0]           dec_dest
);
   import pcseq_pkg::*;

   assign dec_dest = dec_reg_jump ? dec_reg_value : dec_target;

   always_comb begin
      if (!fetch_en)     sel = SEL_HOLD;
      else if (dec_take) sel = SEL_DEC;
      else if (fe_hit)   sel = SEL_FETCH;
      else               sel = SEL_SEQ;
   end
endmodule

// File: rtl/pcseq_link.sv
`timescale 1ns/1ps
// Return address and write strobe for branch-and-link.
module pcseq_link #(
   parameter int unsigned XLEN      = 32,
   parameter int unsigned REG_IDX_W = 5,
   parameter int unsigned LINK_REG  = 31
) (
   input  logic                 fetch_en,
   input  logic                 dec_take,
   input  logic                 dec_link,
   input  logic [XLEN-1:0]      dec_pc,
   output logic [XLEN-1:0]      link_addr,
   output logic [REG_IDX_W-1:0] link_idx,
   output logic                 link_we
);
   localparam logic [XLEN-1:0] SKIP = XLEN'(2 * pcseq_pkg::WORD_BYTES);

   assign link_addr = dec_pc + SKIP;
   assign link_idx  = REG_IDX_W'(LINK_REG);
   assign link_we   = fetch_en & dec_take & dec_link;
endmodule

// File: rtl/pc_sequencer.sv
`timescale 1ns/1ps
module pc_sequencer #(
   parameter int unsigned     XLEN       = pcseq_pkg::DEF_XLEN,
   parameter int unsigned     IMM_W      = pcseq_pkg::DEF_IMM_W,
   parameter int unsigned     REG_IDX_W  = pcseq_pkg::DEF_REG_IDX_W,
   parameter int unsigned     LINK_REG   = pcseq_pkg::DEF_LINK_REG,
   parameter logic [XLEN-1:0] RESET_ADDR = 32'h0040_0000,
   parameter bit              FETCH_BR   = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 fetch_en,
   input  logic                 fe_ubr,
   input  logic [IMM_W-1:0]     fe_imm,
   input  logic                 dec_take,
   input  logic [XLEN-1:0]      dec_target,
   input  logic                 dec_link,
   input  logic                 dec_reg_jump,
   input  logic [XLEN-1:0]      dec_reg_value,
   input  logic [XLEN-1:0]      dec_pc,
   output logic [XLEN-1:0]      fetch_addr,
   output logic [XLEN-1:0]      link_addr,
   output logic [REG_IDX_W-1:0] link_idx,
   output logic                 link_we
);
   import pcseq_pkg::*;

   localparam logic [XLEN-1:0] STEP = XLEN'(WORD_BYTES);

   // Elaboration-time parameter checks
   generate
      if (XLEN < IMM_W + 2) begin : g_bad_width
         initial $fatal(1, "pc_sequencer: XLEN too small for IMM_W");
      end
      if (LINK_REG >= (1 << REG_IDX_W)) begin : g_bad_link
         initial $fatal(1, "pc_sequencer: LINK_REG does not fit REG_IDX_W");
      end
   endgenerate

   logic [XLEN-1:0] pc_q, pc_d, fe_tgt, dec_dest;
   logic            fe_hit;
   pc_sel_e         sel;

   pcseq_fetch_target #(.XLEN(XLEN), .IMM_W(IMM_W), .ENABLE(FETCH_BR)) u_fetch (
      .cur_pc (pc_q),
      .req    (fe_ubr),
      .imm    (fe_imm),
      .hit    (fe_hit),
      .target (fe_tgt)
   );

   pcseq_select #(.XLEN(XLEN)) u_sel (
      .fetch_en      (fetch_en),
      .dec_take      (dec_take),
      .dec_reg_jump  (dec_reg_jump),
      .dec_target    (dec_target),
      .dec_reg_value (dec_reg_value),
      .fe_hit        (fe_hit),
      .sel           (sel),
      .dec_dest      (dec_dest)
   );

   pcseq_link #(.XLEN(XLEN), .REG_IDX_W(REG_IDX_W), .LINK_REG(LINK_REG)) u_link (
      .fetch_en  (fetch_en),
      .dec_take  (dec_take),
      .dec_link  (dec_link),
      .dec_pc    (dec_pc),
      .link_addr (link_addr),
      .link_idx  (link_idx),
      .link_we   (link_we)
   );

   always_comb begin
      unique case (sel)
         SEL_HOLD:  pc_d = pc_q;
         SEL_SEQ:   pc_d = pc_q + STEP;
         SEL_DEC:   pc_d = dec_dest;
         SEL_FETCH: pc_d = fe_tgt;
         default:   pc_d = pc_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) pc_q <= RESET_ADDR;
      else     pc_q <= pc_d;
   end

   assign fetch_addr = pc_q;

   // ---------------- assertions ----------------
   p_reset_addr_r1: assert property (@(posedge clk)
      rst |=> (fetch_addr == RESET_ADDR));

   p_stall_hold_r2: assert property (@(posedge clk) disable iff (rst)
      !fetch_en |=> (fetch_addr == $past(fetch_addr)));

   p_stall_no_link_r2: assert property (@(posedge clk) disable iff (rst)
      !fetch_en |-> !link_we);

   p_sequential_r3: assert property (@(posedge clk) disable iff (rst)
      (fetch_en && !dec_take && !fe_ubr) |=> (fetch_addr == $past(fetch_addr) + STEP));

   p_dec_target_r4: assert property (@(posedge clk) disable iff (rst)
      (fetch_en && dec_take && !dec_reg_jump) |=> (fetch_addr == $past(dec_target)));

   p_reg_jump_r6: assert property (@(posedge clk) disable iff (rst)
      (fetch_en && dec_take && dec_reg_jump) |=> (fetch_addr == $past(dec_reg_value)));

   p_link_addr_r7: assert property (@(posedge clk) disable iff (rst)
      link_we |-> (link_addr == dec_pc + XLEN'(2 * WORD_BYTES)));

   p_link_needs_take_r5: assert property (@(posedge clk) disable iff (rst)
      !dec_take |-> !link_we);

   generate
      if (FETCH_BR) begin : g_fetch_chk
         p_fetch_branch_r8: assert property (@(posedge clk) disable iff (rst)
            (fetch_en && !dec_take && fe_ubr) |=>
            (fetch_addr == $past(fetch_addr) + STEP +
               {{(XLEN-IMM_W-2){$past(fe_imm[IMM_W-1])}}, $past(fe_imm), 2'b00}));
      end
   endgenerate

   p_decode_wins_r9: assert property (@(posedge clk) disable iff (rst)
      (fetch_en && dec_take && fe_ubr && !dec_reg_jump) |=> (fetch_addr == $past(dec_target)));
endmodule

// File: tb/pc_sequencer_test.sv
`timescale 1ns/1ps
module pc_sequencer_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        fetch_en = 1'b0, fe_ubr = 1'b0, dec_take = 1'b0;
   logic        dec_link = 1'b0, dec_reg_jump = 1'b0;
   logic [15:0] fe_imm = '0;
   logic [31:0] dec_target = '0, dec_reg_value = '0, dec_pc = '0;
   logic [31:0] fetch_addr, link_addr;
   logic [4:0]  link_idx;
   logic        link_we;

   int errors = 0;
   int checks = 0;

   always #4 clk = ~clk;   // 125 MHz

   pc_sequencer uut (
      .clk(clk), .rst(rst), .fetch_en(fetch_en), .fe_ubr(fe_ubr), .fe_imm(fe_imm),
      .dec_take(dec_take), .dec_target(dec_target), .dec_link(dec_link),
      .dec_reg_jump(dec_reg_jump), .dec_reg_value(dec_reg_value), .dec_pc(dec_pc),
      .fetch_addr(fetch_addr), .link_addr(link_addr), .link_idx(link_idx),
      .link_we(link_we)
   );

   typedef struct packed {
      logic        fe;
      logic        take;
      logic        lnk;
      logic        rj;
      logic        ubr;
      logic [15:0] imm;
      logic [31:0] tgt;
      logic [31:0] rv;
      logic [31:0] bpc;
      logic [31:0] exp_pc;
      logic        exp_we;
      logic [31:0] exp_link;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 12;
   // fe take lnk rj ubr imm tgt rv bpc exp_pc exp_we exp_link req
   localparam vec_t VECS [0:NV-1] = '{
      '{1'b1,1'b0,1'b0,1'b0,1'b0,16'h0000,32'h0,32'h0,32'h0,32'h0040_0004,1'b0,32'h0,4'd3},               // R3 step
      '{1'b0,1'b1,1'b1,1'b0,1'b0,16'h0000,32'h0050_0000,32'h0,32'h0,32'h0040_0004,1'b0,32'h0,4'd2},       // R2 stall ignores branch
      '{1'b1,1'b1,1'b1,1'b0,1'b0,16'h0000,32'h0040_1000,32'h0,32'h0040_0000,32'h0040_1000,1'b1,32'h0040_0008,4'd4}, // R4 + R7
      '{1'b1,1'b0,1'b0,1'b0,1'b0,16'h0000,32'h0,32'h0,32'h0,32'h0040_1004,1'b0,32'h0,4'd3},               // R3
      '{1'b1,1'b1,1'b0,1'b1,1'b0,16'h0000,32'hDEAD_0000,32'h0040_0008,32'h0,32'h0040_0008,1'b0,32'h0,4'd6}, // R6
      '{1'b1,1'b0,1'b0,1'b0,1'b1,16'h0010,32'h0,32'h0,32'h0,32'h0040_004C,1'b0,32'h0,4'd8},               // R8 positive
      '{1'b1,1'b0,1'b0,1'b0,1'b1,16'hFFFF,32'h0,32'h0,32'h0,32'h0040_004C,1'b0,32'h0,4'd8},               // R8 minus one word
      '{1'b1,1'b0,1'b0,1'b0,1'b1,16'hFFF0,32'h0,32'h0,32'h0,32'h0040_0010,1'b0,32'h0,4'd8},               // R8 negative
      '{1'b1,1'b1,1'b0,1'b0,1'b1,16'h0100,32'h0040_2000,32'h0,32'h0,32'h0040_2000,1'b0,32'h0,4'd9},       // R9
      '{1'b1,1'b0,1'b1,1'b0,1'b0,16'h0000,32'h0050_0000,32'h0,32'h0040_1FFC,32'h0040_2004,1'b0,32'h0,4'd5}, // R5
      '{1'b0,1'b0,1'b0,1'b0,1'b1,16'h0010,32'h0,32'h0,32'h0,32'h0040_2004,1'b0,32'h0,4'd2},               // R2 stall ignores fetch branch
      '{1'b1,1'b1,1'b1,1'b1,1'b1,16'h0040,32'h0060_0000,32'h0040_0100,32'h0040_2000,32'h0040_0100,1'b1,32'h0040_2008,4'd9}  // R9 + R6 + R7
   };

   task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   task automatic idle_inputs();
      fe_ubr = 1'b0; dec_take = 1'b0; dec_link = 1'b0; dec_reg_jump = 1'b0;
      fe_imm = '0; dec_target = '0; dec_reg_value = '0; dec_pc = '0;
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check32("R1 reset address", fetch_addr, 32'h0040_0000);
      rst = 1'b0;
      @(negedge clk);
      check32("R1 first cycle after reset", fetch_addr, 32'h0040_0000);
      check32("R7 link index", {27'd0, link_idx}, 32'd31);

      for (int i = 0; i < NV; i++) begin
         fetch_en = VECS[i].fe; dec_take = VECS[i].take; dec_link = VECS[i].lnk;
         dec_reg_jump = VECS[i].rj; fe_ubr = VECS[i].ubr; fe_imm = VECS[i].imm;
         dec_target = VECS[i].tgt; dec_reg_value = VECS[i].rv; dec_pc = VECS[i].bpc;
         #1;
         check32($sformatf("R%0d row %0d link_we", VECS[i].req, i), {31'd0, link_we}, {31'd0, VECS[i].exp_we});
         if (VECS[i].exp_we)
            check32($sformatf("R7 row %0d link_addr", i), link_addr, VECS[i].exp_link);
         @(negedge clk);
         check32($sformatf("R%0d row %0d fetch_addr", VECS[i].req, i), fetch_addr, VECS[i].exp_pc);
      end

      // R4 delay slot: branch at B sits in decode while B+4 is fetched
      idle_inputs();
      fetch_en = 1'b1;
      @(negedge clk);                               // fetch_addr = 0x00400104 (branch)
      check32("R3 step before branch", fetch_addr, 32'h0040_0104);
      @(negedge clk);                               // delay slot fetched
      check32("R4 delay slot fetched", fetch_addr, 32'h0040_0108);
      dec_take = 1'b1; dec_target = 32'h0040_3000; dec_pc = 32'h0040_0104;
      @(negedge clk);
      check32("R4 target after delay slot", fetch_addr, 32'h0040_3000);
      idle_inputs();

      // R1 reset mid-run
      rst = 1'b1;
      @(negedge clk);
      check32("R1 mid-run reset", fetch_addr, 32'h0040_0000);
      rst = 1'b0;
      fetch_en = 1'b0;
      @(negedge clk);
      check32("R2 hold after reset", fetch_addr, 32'h0040_0000);

      finish_run();
   end
endmodule